// File: doc/BRIEF.md
# Match-Line Refresh Scheduling Controller

This block schedules recharging for a match array that is split into segments, where a row that misses a search keeps its match-line charge and only a row that hits loses it. After every search the controller issues a one-cycle selective recharge strobe for exactly the rows that hit. It also keeps a search counter for each segment. When a segment has used up its refresh period, the controller issues a full recharge of that segment. Idle cycles do not use up the period.

Approximation works by stretching the refresh period, and it is applied from the least significant segment upward. A configuration input selects how many low-order segments run approximate and at which tolerance depth. The same depth applies to all of those segments. Each segment reports its tolerance code. Any change of configuration forces a full recharge of every segment and restarts all counters. Voltage behaviour of the match lines is not modelled; only the strobes and codes are produced.

Top module: `mlrefresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, every selective and full recharge strobe is 0 and every tolerance code is exact (00).
- R2: In the cycle after a counted search, `selPrecharge` equals that search's `hitRows` (bit seg*NUM_ROWS+row), except for segments given in R8. The strobe lasts one cycle, and `selPrecharge` is all 0 after a cycle with no search.
- R3: In the cycle after the P-th counted search since a segment's last full recharge, that segment's `fullPrecharge` bit is 1 for one cycle. Its count then restarts from zero.
- R4: The period P in exact mode depends on SEG_BITS: 7 for 2-bit segments, 5 for 4-bit segments and 4 for 8-bit segments. With access transistors (CROSSBAR=0), 1-HD adds 2 and 2-HD adds 4. With CROSSBAR=1, 1-HD adds 1 and 2-HD adds 3.
- R5: A cycle with `searchValid` low does not advance any segment count and produces no strobe.
- R6: Segment i gets tolerance code `cfgDepth` when i < `cfgApproxSegs`, and 00 otherwise. The codes are 00 exact, 01 1-HD and 10 2-HD. A depth of 11 acts as 10. An approximate count larger than NUM_SEG is treated as NUM_SEG.
- R7: In the cycle after the configuration inputs differ from the held configuration, every `fullPrecharge` bit is 1 and `selPrecharge` is 0. All counts restart, and a search in the cycle of the change is not counted.
- R8: In any cycle where a segment's `fullPrecharge` bit is 1, all of that segment's `selPrecharge` bits are 0.
- R9: The tolerance codes keep their old values in the cycle in which the configuration inputs change. They show the new configuration from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| searchValid | input | 1 | A search takes place this cycle |
| hitRows | input | NUM_SEG*NUM_ROWS | Rows of each segment that hit in this search |
| cfgApproxSegs | input | $clog2(NUM_SEG+1) | Number of low-order segments run approximate |
| cfgDepth | input | 2 | Approximation depth: 00 exact, 01 1-HD, 10/11 2-HD |
| selPrecharge | output | NUM_SEG*NUM_ROWS | Selective recharge strobe per row |
| fullPrecharge | output | NUM_SEG | Full recharge strobe per segment |
| tolCode | output | 2*NUM_SEG | Tolerance code per segment, 2 bits each |

## Verification
The bench runs long streams of back-to-back searches in mixed configurations, so that exact and approximate segments reach their full recharge on different searches. A design with an off-by-one period would strobe one search early or late. A design that shares one counter across segments would strobe all segments together. Idle gaps in the middle of a period expose a design that counts cycles instead of searches. Searches issued in the same cycle as a configuration change, and as a full recharge, expose a design that counts the discarded search or leaves selective strobes on for a segment being fully recharged. The bench also drives an out-of-range segment count and a depth of 11, which would give wrong tolerance codes if clamping were missing.

// File: rtl/mlrefresh_pkg.sv
package mlrefresh_pkg;

  typedef enum logic [1:0] {
    TOL_EXACT = 2'b00,
    TOL_HD1   = 2'b01,
    TOL_HD2   = 2'b10
  } tol_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadHits;   // counted search this cycle
    logic flushAll;   // configuration change: recharge every segment
  } strobe_t;

  // Exact-mode period from segment width (R4)
  function automatic int exactPeriod(input int segBits);
    if (segBits <= 2)      return 7;
    else if (segBits <= 4) return 5;
    else                   return 4;
  endfunction

  function automatic int refreshPeriod(input int segBits, input bit xbar,
                                       input logic [1:0] tol);
    int base;
    base = exactPeriod(segBits);
    case (tol)
      TOL_HD1: return xbar ? base + 1 : base + 2;
      TOL_HD2: return xbar ? base + 3 : base + 4;
      default: return base;
    endcase
  endfunction

endpackage

// File: rtl/mlr_ctrl.sv
module mlr_ctrl
  import mlrefresh_pkg::*;
#(
  parameter int NUM_SEG  = 4,
  parameter int SEG_BITS = 8,
  parameter int CROSSBAR = 0,
  parameter int M_W      = $clog2(NUM_SEG + 1),
  parameter int CNT_W    = $clog2(exactPeriod(SEG_BITS) + 5)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 searchValid,
  input  logic [M_W-1:0]       cfgApproxSegs,
  input  logic [1:0]           cfgDepth,
  output strobe_t              strb,
  output logic [NUM_SEG-1:0]   fullDue,
  output logic [2*NUM_SEG-1:0] tolCode
);

  logic [M_W-1:0] mIn, mQ;
  logic [1:0]     dIn, dQ;
  logic           flush;

  // Clamp configuration (R6)
  assign mIn   = (cfgApproxSegs > M_W'(NUM_SEG)) ? M_W'(NUM_SEG) : cfgApproxSegs;
  assign dIn   = (cfgDepth == 2'b11) ? TOL_HD2 : cfgDepth;
  assign flush = (mIn != mQ) || (dIn != dQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mQ <= '0;
      dQ <= TOL_EXACT;
    end else begin
      mQ <= mIn;
      dQ <= dIn;
    end
  end

  assign strb.loadHits = searchValid && !flush;
  assign strb.flushAll = flush;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic [1:0]       segTol;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] cnt;
    logic             lastSearch;

    assign segTol = (M_W'(i) < mQ) ? dQ : TOL_EXACT;
    assign tolCode[2*i +: 2] = segTol;

    always_comb per = CNT_W'(refreshPeriod(SEG_BITS, CROSSBAR != 0, segTol));

    assign lastSearch = (cnt == per - CNT_W'(1));
    assign fullDue[i] = searchValid && !flush && lastSearch;

    always_ff @(posedge clk) begin
      if (!rstN || flush)       cnt <= '0;
      else if (searchValid) begin
        if (lastSearch)         cnt <= '0;
        else                    cnt <= cnt + CNT_W'(1);
      end
    end

    // R3: the count never reaches the period
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
      cnt < per);
    // R7: a configuration change restarts the count
    a_r7_flush_restarts: assert property (@(posedge clk) disable iff (!rstN)
      flush |=> cnt == '0);
    // R5: idle cycles hold the count
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!searchValid && !flush) |=> $stable(cnt));
    if (i > 0) begin : g_order
      // R6: approximation grows from the lowest segment upward
      a_r6_low_first: assert property (@(posedge clk) disable iff (!rstN)
        (tolCode[2*i +: 2] != TOL_EXACT) |-> (tolCode[2*(i-1) +: 2] != TOL_EXACT));
    end
  end

endmodule

// File: rtl/mlr_datapath.sv
module mlr_datapath
  import mlrefresh_pkg::*;
#(
  parameter int NUM_SEG  = 4,
  parameter int NUM_ROWS = 4,
  localparam int TOT_ROWS = NUM_SEG * NUM_ROWS
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [NUM_SEG-1:0]  fullDue,
  input  logic [TOT_ROWS-1:0] hitRows,
  output logic [TOT_ROWS-1:0] selPrecharge,
  output logic [NUM_SEG-1:0]  fullPrecharge
);

  logic [TOT_ROWS-1:0] selNext;
  logic [NUM_SEG-1:0]  fullNext;

  assign fullNext = strb.flushAll ? '1 : fullDue;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    // Full recharge of a segment supersedes its selective strobes (R8)
    assign selNext[s*NUM_ROWS +: NUM_ROWS] =
      (strb.loadHits && !fullDue[s]) ? hitRows[s*NUM_ROWS +: NUM_ROWS] : '0;

    // R8: never both kinds of strobe on one segment
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
      fullPrecharge[s] |-> (selPrecharge[s*NUM_ROWS +: NUM_ROWS] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPrecharge  <= '0;
      fullPrecharge <= '0;
    end else begin
      selPrecharge  <= selNext;
      fullPrecharge <= fullNext;
    end
  end

  // R2: only rows that hit in the previous cycle are recharged
  a_r2_sel_subset: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((selPrecharge & ~$past(hitRows)) == '0));
  // R7: configuration change recharges every segment
  a_r7_flush_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (&fullPrecharge && selPrecharge == '0));

endmodule

// File: rtl/mlrefresh_sched.sv
module mlrefresh_sched
  import mlrefresh_pkg::*;
#(
  parameter int NUM_SEG  = 4,
  parameter int SEG_BITS = 8,
  parameter int NUM_ROWS = 4,
  parameter int CROSSBAR = 0,
  localparam int M_W      = $clog2(NUM_SEG + 1),
  localparam int TOT_ROWS = NUM_SEG * NUM_ROWS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 searchValid,
  input  logic [TOT_ROWS-1:0]  hitRows,
  input  logic [M_W-1:0]       cfgApproxSegs,
  input  logic [1:0]           cfgDepth,
  output logic [TOT_ROWS-1:0]  selPrecharge,
  output logic [NUM_SEG-1:0]   fullPrecharge,
  output logic [2*NUM_SEG-1:0] tolCode
);

  strobe_t            strb;
  logic [NUM_SEG-1:0] fullDue;

  mlr_ctrl #(
    .NUM_SEG(NUM_SEG), .SEG_BITS(SEG_BITS), .CROSSBAR(CROSSBAR), .M_W(M_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .searchValid(searchValid),
    .cfgApproxSegs(cfgApproxSegs), .cfgDepth(cfgDepth),
    .strb(strb), .fullDue(fullDue), .tolCode(tolCode)
  );

  mlr_datapath #(.NUM_SEG(NUM_SEG), .NUM_ROWS(NUM_ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fullDue(fullDue),
    .hitRows(hitRows), .selPrecharge(selPrecharge), .fullPrecharge(fullPrecharge)
  );

endmodule

// File: tb/mlrefresh_sched_bench.sv
module mlrefresh_sched_bench;
  localparam int NSEG = 4;
  localparam int NROW = 4;
  localparam int TOT  = NSEG * NROW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            searchValid = 1'b0;
  logic [TOT-1:0]  hitRows = '0;
  logic [2:0]      cfgApproxSegs = '0;
  logic [1:0]      cfgDepth = '0;
  logic [TOT-1:0]  selPrecharge;
  logic [NSEG-1:0] fullPrecharge;
  logic [2*NSEG-1:0] tolCode;

  int checks = 0, fails = 0;
  int bcnt[NSEG];
  int curM = 0, curD = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mlrefresh_sched #(.NUM_SEG(NSEG), .SEG_BITS(8), .NUM_ROWS(NROW), .CROSSBAR(0))
    u_mlrefresh_sched (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R4 / R6: period from tolerance for 8-bit segments with access transistors
  function automatic int benchPer(input int seg);
    int tol;
    tol = (seg < curM) ? curD : 0;
    return (tol == 1) ? 6 : (tol == 2) ? 8 : 4;
  endfunction

  function automatic logic [2*NSEG-1:0] expTol();
    logic [2*NSEG-1:0] t;
    for (int s = 0; s < NSEG; s++) t[2*s +: 2] = (s < curM) ? 2'(curD) : 2'b00;
    return t;
  endfunction

  task automatic searchStep(input logic [TOT-1:0] hits);
    logic [NSEG-1:0] expFull;
    logic [TOT-1:0]  expSel;
    searchValid = 1'b1;
    hitRows = hits;
    expSel = hits;
    for (int s = 0; s < NSEG; s++) begin
      if (bcnt[s] + 1 == benchPer(s)) begin
        expFull[s] = 1'b1;
        bcnt[s] = 0;
        expSel[s*NROW +: NROW] = '0;
      end else begin
        expFull[s] = 1'b0;
        bcnt[s]++;
      end
    end
    @(negedge clk);
    searchValid = 1'b0;
    check(fullPrecharge == expFull, "R3", "full strobe", 32'(fullPrecharge), 32'(expFull));
    check(selPrecharge == expSel, "R2/R8", "selective strobe", 32'(selPrecharge), 32'(expSel));
  endtask

  task automatic idleStep();
    searchValid = 1'b0;
    hitRows = '1;
    @(negedge clk);
    check(selPrecharge == '0 && fullPrecharge == '0, "R5", "idle strobes",
          32'({selPrecharge, fullPrecharge}), 32'h0);
  endtask

  task automatic setCfg(input int m, input int d);
    logic [2*NSEG-1:0] oldTol;
    oldTol = expTol();
    cfgApproxSegs = 3'(m);
    cfgDepth = 2'(d);
    searchValid = 1'b1;
    hitRows = '1;
    #1;
    check(tolCode == oldTol, "R9", "tol before update", 32'(tolCode), 32'(oldTol));
    @(negedge clk);
    searchValid = 1'b0;
    curM = (m > NSEG) ? NSEG : m;
    curD = (d == 3) ? 2 : d;
    for (int s = 0; s < NSEG; s++) bcnt[s] = 0;
    check(fullPrecharge == '1, "R7", "flush full", 32'(fullPrecharge), 32'hF);
    check(selPrecharge == '0, "R7", "flush selective", 32'(selPrecharge), 32'h0);
    check(tolCode == expTol(), "R6", "tolerance codes", 32'(tolCode), 32'(expTol()));
  endtask

  task automatic testReset();
    check(selPrecharge == '0 && fullPrecharge == '0, "R1", "reset strobes",
          32'({selPrecharge, fullPrecharge}), 32'h0);
    check(tolCode == '0, "R1", "reset tol", 32'(tolCode), 32'h0);
  endtask

  task automatic testExact();
    for (int k = 0; k < 9; k++) searchStep(16'hA5C3 ^ 16'(k * 16'h1111));
  endtask

  task automatic testIdle();
    searchStep(16'h0F0F);
    searchStep(16'h1234);
    idleStep(); idleStep(); idleStep();
    searchStep(16'hFFFF);
    searchStep(16'h8421);
    searchStep(16'h00F0);
  endtask

  task automatic testMixed();
    setCfg(2, 1);
    for (int k = 0; k < 13; k++) searchStep(16'h3C5A + 16'(k * 7));
  endtask

  task automatic testClamp();
    setCfg(5, 3);
    for (int k = 0; k < 9; k++) begin
      searchStep(16'hFFFF);
      if (k == 3) idleStep();
    end
    setCfg(0, 0);
    searchStep(16'h0001);
  endtask

  initial begin
    for (int s = 0; s < NSEG; s++) bcnt[s] = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExact();
    testIdle();
    testMixed();
    testClamp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule